// File: doc/BRIEF.md
# Cyclic Prefix Register Dataflow Network

This block links a ring of execution stations that together form an in-order issue and retire window. For every logical register name, each station receives the operand it should consume: the value and ready flag from the closest older station in program order that writes that register. If no older station in the window writes the register, the station receives the committed architectural value, which is always marked ready. Each station thus sees a private, complete copy of the logical register set. This gives full renaming at every station without a shared physical register file or associative wakeup logic.

The network is a segmented parallel-prefix scan of logarithmic depth over the stations. It is run once per logical register. A station that writes the register replaces whatever arrives from older stations, and any other station passes it through. The window is circular, so the scan starts at the head pointer and wraps around the end of the ring. The oldest station is seeded from the committed register file. The scan is exclusive: a station's own write feeds only younger stations. When the head station is valid and has finished, its writes enter the committed register file on the clock edge and the head advances by one. The surrounding issue logic is expected to empty that slot.

The station write, done and valid pins are plain, level-sensitive control and data with no handshake. The block applies no back-pressure, and operands are a combinational function of the station inputs, the head pointer and the committed state. The parameters set the ring size, the register count and the value width. A full-size window of 128 stations, 32 registers and 64-bit values is set by overriding them.

Top module: `regflow_ring`

## Requirements
- R1: For station s and register r, the operand value is the write value of the nearest valid station that is older than s in ring order starting at the head and that has the write-enable bit for r set.
- R2: When no valid older station writes register r, station s receives the committed value of r, and its ready bit is 1.
- R3: An operand supplied by an older station is ready exactly when that station's done input is 1.
- R4: A station's own write never reaches its own operand outputs, so the head station always sees the committed file, all ready.
- R5: A station whose valid input is 0 passes operands through for every register, whatever its write-enable bits and data.
- R6: Age order is cyclic from the head: stations with an index below the head are younger than those at or above it, and the scan wraps from the last index to index 0.
- R7: When the head station is valid and done, on the clock edge its write-enabled registers are copied into the committed file, other registers keep their values, and the head becomes (head+1) mod N_STN.
- R8: When the head station is not valid or not done, the head and the committed file hold.
- R9: After reset the head is 0 and every committed register is 0, so with an idle window all operands are 0 and ready.
- R10: Registers are independent: a write to one register never changes the operand delivered for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stn_valid | input | N_STN | Station holds an instruction |
| stn_done | input | N_STN | Station result is computed |
| stn_wen | input | N_STN x N_REG | Per-station, per-register write enable |
| stn_wdata | input | N_STN x N_REG x VAL_W | Per-station, per-register result value |
| head_idx | output | log2(N_STN) | Index of the oldest station |
| opnd_val | output | N_STN x N_REG x VAL_W | Operand value delivered to each station, per register |
| opnd_rdy | output | N_STN x N_REG | Operand ready flag, per station and register |

## Verification
The bench targets the corner cases of the scan. It checks that a writer is not fed back to itself, which an inclusive scan would get wrong by handing the head its own result. It checks that an invalid slot with stale write bits is ignored rather than treated as a producer. It moves the head past the end of the ring so that low-index stations must draw from high-index ones; a non-cyclic scan would instead deliver committed values there. It also verifies that ready follows the producer's done flag and not the consumer's. Retire checks confirm that registers the head did not write keep their committed values, and that a head which is not done leaves everything unchanged.

// File: rtl/regflow_pkg.sv
package regflow_pkg;
  // Bits needed to index n items; at least one bit.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/regflow_rotate.sv
// Logarithmic barrel rotation of a ring of N elements of E bits each.
// BACK = 0: dout[j] = din[(j + amt) mod N]   (absolute -> head-relative)
// BACK = 1: dout[j] = din[(j - amt) mod N]   (head-relative -> absolute)
module regflow_rotate #(
  parameter int N    = 16,
  parameter int E    = 8,
  parameter bit BACK = 1'b0
) (
  input  logic [N-1:0][E-1:0]                        din,
  input  logic [regflow_pkg::idx_bits(N)-1:0]        amt,
  output logic [N-1:0][E-1:0]                        dout
);
  localparam int SW = regflow_pkg::idx_bits(N);

  logic [N-1:0][E-1:0] stg [0:SW];

  assign stg[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = (1 << k) % N;
    for (genvar j = 0; j < N; j++) begin : g_elem
      localparam int SRC = BACK ? ((j - SH + N) % N) : ((j + SH) % N);
      assign stg[k+1][j] = amt[k] ? stg[k][SRC] : stg[k][j];
    end
  end

  assign dout = stg[SW];
endmodule

// File: rtl/regflow_scan.sv
// Exclusive segmented prefix scan for one logical register, in head-relative
// order. Element 0 of the inclusive scan is the committed seed, element i is
// station i-1, so output i covers the seed and stations 0..i-1 only.
module regflow_scan #(
  parameter int N = 16,
  parameter int W = 32
) (
  input  logic [W-1:0]          seed,
  input  logic [N-1:0]          gen,
  input  logic [N-1:0]          rdy,
  input  logic [N-1:0][W-1:0]   val,
  output logic [N-1:0][W-1:0]   o_val,
  output logic [N-1:0]          o_rdy
);
  localparam int LG = regflow_pkg::idx_bits(N);

  logic [N-1:0]        g_l [0:LG];
  logic [N-1:0]        r_l [0:LG];
  logic [N-1:0][W-1:0] v_l [0:LG];

  // Level 0: shift stations one place younger, insert the seed at the front.
  for (genvar i = 0; i < N; i++) begin : g_lvl0
    if (i == 0) begin : g_seed
      assign g_l[0][i] = 1'b1;
      assign r_l[0][i] = 1'b1;
      assign v_l[0][i] = seed;
    end else begin : g_stn
      assign g_l[0][i] = gen[i-1];
      assign r_l[0][i] = rdy[i-1];
      assign v_l[0][i] = val[i-1];
    end
  end

  // Kogge-Stone combine: a generating younger segment wins, else the older one passes.
  for (genvar k = 0; k < LG; k++) begin : g_lvl
    localparam int D = 1 << k;
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= D) begin : g_comb
        assign g_l[k+1][i] = g_l[k][i] | g_l[k][i-D];
        assign r_l[k+1][i] = g_l[k][i] ? r_l[k][i] : r_l[k][i-D];
        assign v_l[k+1][i] = g_l[k][i] ? v_l[k][i] : v_l[k][i-D];
      end else begin : g_pass
        assign g_l[k+1][i] = g_l[k][i];
        assign r_l[k+1][i] = r_l[k][i];
        assign v_l[k+1][i] = v_l[k][i];
      end
    end
  end

  assign o_val = v_l[LG];
  assign o_rdy = r_l[LG];
endmodule

// File: rtl/regflow_commit.sv
// Committed register file and head pointer.
module regflow_commit #(
  parameter int N = 16,
  parameter int R = 8,
  parameter int W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   retire,
  input  logic [R-1:0]                           wen,
  input  logic [R-1:0][W-1:0]                    wdata,
  output logic [regflow_pkg::idx_bits(N)-1:0]    head,
  output logic [R-1:0][W-1:0]                    crf
);
  localparam int HW = regflow_pkg::idx_bits(N);
  localparam logic [HW-1:0] LAST = HW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      crf  <= '0;
    end else if (retire) begin
      head <= (head == LAST) ? '0 : head + 1'b1;
      for (int r = 0; r < R; r++) begin
        if (wen[r]) crf[r] <= wdata[r];
      end
    end
  end

  // R7: head steps by one, wrapping at the ring end
  p_head_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (head == (($past(head) == LAST) ? '0 : $past(head) + 1'b1)));

  // R8: nothing moves without a retirement
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> ($stable(head) && $stable(crf)));

  for (genvar r = 0; r < R; r++) begin : g_chk
    // R7: unwritten registers keep their committed value
    p_crf_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !wen[r]) |=> $stable(crf[r]));
    // R7: written registers take the retiring value
    p_crf_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && wen[r]) |=> (crf[r] == $past(wdata[r])));
  end
endmodule

// File: rtl/regflow_ring.sv
// Top: rotate stations into head-relative order, scan each register, rotate back.
module regflow_ring #(
  parameter int N_STN = 16,
  parameter int N_REG = 8,
  parameter int VAL_W = 32
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [N_STN-1:0]                           stn_valid,
  input  logic [N_STN-1:0]                           stn_done,
  input  logic [N_STN-1:0][N_REG-1:0]                stn_wen,
  input  logic [N_STN-1:0][N_REG-1:0][VAL_W-1:0]     stn_wdata,
  output logic [regflow_pkg::idx_bits(N_STN)-1:0]    head_idx,
  output logic [N_STN-1:0][N_REG-1:0][VAL_W-1:0]     opnd_val,
  output logic [N_STN-1:0][N_REG-1:0]                opnd_rdy
);
  localparam int HW  = regflow_pkg::idx_bits(N_STN);
  localparam int EIN = N_REG * VAL_W + N_REG + 1;
  localparam int EOU = N_REG * (VAL_W + 1);

  logic [HW-1:0]                  head_q;
  logic [N_REG-1:0][VAL_W-1:0]    crf;
  logic                           retire;

  logic [N_STN-1:0][EIN-1:0]              fwd_in, fwd_out;
  logic [N_STN-1:0]                       rel_done;
  logic [N_STN-1:0][N_REG-1:0]            rel_wen;
  logic [N_STN-1:0][N_REG-1:0][VAL_W-1:0] rel_data;

  logic [N_REG-1:0][N_STN-1:0]            t_gen, t_rdy, s_rdy;
  logic [N_REG-1:0][N_STN-1:0][VAL_W-1:0] t_val, s_val;

  logic [N_STN-1:0][EOU-1:0]              back_in, back_out;

  assign retire   = stn_valid[head_q] & stn_done[head_q];
  assign head_idx = head_q;

  regflow_commit #(.N(N_STN), .R(N_REG), .W(VAL_W)) u_commit (
    .clk    (clk),
    .rst_n  (rst_n),
    .retire (retire),
    .wen    (stn_wen[head_q]),
    .wdata  (stn_wdata[head_q]),
    .head   (head_q),
    .crf    (crf)
  );

  // Pack each station; invalid stations never generate.
  for (genvar i = 0; i < N_STN; i++) begin : g_pack
    assign fwd_in[i]   = {stn_wdata[i], stn_wen[i] & {N_REG{stn_valid[i]}}, stn_done[i]};
    assign rel_done[i] = fwd_out[i][0];
    assign rel_wen[i]  = fwd_out[i][N_REG:1];
    assign rel_data[i] = fwd_out[i][EIN-1:N_REG+1];
  end

  regflow_rotate #(.N(N_STN), .E(EIN), .BACK(1'b0)) u_rot_in (
    .din  (fwd_in),
    .amt  (head_q),
    .dout (fwd_out)
  );

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    for (genvar i = 0; i < N_STN; i++) begin : g_tr
      assign t_gen[r][i] = rel_wen[i][r];
      assign t_rdy[r][i] = rel_done[i];
      assign t_val[r][i] = rel_data[i][r];
      assign back_in[i][r*(VAL_W+1) +: VAL_W+1] = {s_rdy[r][i], s_val[r][i]};
    end

    regflow_scan #(.N(N_STN), .W(VAL_W)) u_scan (
      .seed  (crf[r]),
      .gen   (t_gen[r]),
      .rdy   (t_rdy[r]),
      .val   (t_val[r]),
      .o_val (s_val[r]),
      .o_rdy (s_rdy[r])
    );
  end

  regflow_rotate #(.N(N_STN), .E(EOU), .BACK(1'b1)) u_rot_out (
    .din  (back_in),
    .amt  (head_q),
    .dout (back_out)
  );

  for (genvar i = 0; i < N_STN; i++) begin : g_out
    for (genvar r = 0; r < N_REG; r++) begin : g_o
      assign opnd_val[i][r] = back_out[i][r*(VAL_W+1) +: VAL_W];
      assign opnd_rdy[i][r] = back_out[i][r*(VAL_W+1) + VAL_W];
    end
  end

  // R2/R4: the oldest station only ever sees the committed file, all ready
  p_head_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&opnd_rdy[head_q]));
  p_head_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_val[head_q] == crf));
endmodule

// File: tb/test_regflow_ring.sv
module test_regflow_ring;
  localparam int N  = 8;
  localparam int R  = 8;
  localparam int W  = 16;
  localparam int HW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]                stn_valid, stn_done;
  logic [N-1:0][R-1:0]         stn_wen;
  logic [N-1:0][R-1:0][W-1:0]  stn_wdata;
  logic [HW-1:0]               head_idx;
  logic [N-1:0][R-1:0][W-1:0]  opnd_val;
  logic [N-1:0][R-1:0]         opnd_rdy;

  // bench-side stimulus and model
  logic          b_valid [N];
  logic          b_done  [N];
  logic          b_wen   [N][R];
  logic [W-1:0]  b_data  [N][R];
  logic [W-1:0]  m_crf   [R];
  int            m_head;
  int            checks = 0;
  int            errors = 0;

  always_comb begin
    for (int s = 0; s < N; s++) begin
      stn_valid[s] = b_valid[s];
      stn_done[s]  = b_done[s];
      for (int r = 0; r < R; r++) begin
        stn_wen[s][r]   = b_wen[s][r];
        stn_wdata[s][r] = b_data[s][r];
      end
    end
  end

  regflow_ring #(.N_STN(N), .N_REG(R), .VAL_W(W)) i_regflow_ring (
    .clk(clk), .rst_n(rst_n),
    .stn_valid(stn_valid), .stn_done(stn_done),
    .stn_wen(stn_wen), .stn_wdata(stn_wdata),
    .head_idx(head_idx), .opnd_val(opnd_val), .opnd_rdy(opnd_rdy)
  );

  task automatic clear_all();
    for (int s = 0; s < N; s++) begin
      b_valid[s] = 1'b0; b_done[s] = 1'b0;
      for (int r = 0; r < R; r++) begin b_wen[s][r] = 1'b0; b_data[s][r] = '0; end
    end
  endtask

  // linear backward scan toward the head
  task automatic ref_of(input int s, input int r, output logic [W-1:0] v, output logic rd);
    int d;
    d  = (s - m_head + N) % N;
    v  = m_crf[r];
    rd = 1'b1;
    for (int k = 1; k <= d; k++) begin
      int j;
      j = (s - k + N) % N;
      if (b_valid[j] && b_wen[j][r]) begin
        v = b_data[j][r]; rd = b_done[j];
        return;
      end
    end
  endtask

  task automatic check_op(input string req, input int s, input int r,
                          input logic [W-1:0] ev, input logic er);
    checks++;
    if (opnd_val[s][r] !== ev || opnd_rdy[s][r] !== er) begin
      errors++;
      $display("FAIL %s stn%0d reg%0d: actual val=%h rdy=%b expected val=%h rdy=%b",
               req, s, r, opnd_val[s][r], opnd_rdy[s][r], ev, er);
    end
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < N; s++)
      for (int r = 0; r < R; r++) begin
        logic [W-1:0] ev; logic er;
        ref_of(s, r, ev, er);
        check_op(req, s, r, ev, er);
      end
  endtask

  task automatic check_head(input string req);
    checks++;
    if (head_idx !== HW'(m_head)) begin
      errors++;
      $display("FAIL %s head: actual %0d expected %0d", req, head_idx, m_head);
    end
  endtask

  // one clock: model retires exactly as R7/R8 state, then settle after negedge
  task automatic step();
    @(posedge clk);
    if (b_valid[m_head] && b_done[m_head]) begin
      for (int r = 0; r < R; r++) if (b_wen[m_head][r]) m_crf[r] = b_data[m_head][r];
      m_head = (m_head + 1) % N;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();   // R9
    clear_all(); #1;
    check_head("R9");
    check_all("R9");
  endtask

  task automatic t_chain();   // R1 R3 R4
    clear_all();
    b_valid[2] = 1; b_done[2] = 1; b_wen[2][1] = 1; b_data[2][1] = 16'hA1A1;
    b_valid[5] = 1; b_done[5] = 0; b_wen[5][1] = 1; b_data[5][1] = 16'hB5B5;
    #1;
    check_op("R1", 3, 1, 16'hA1A1, 1'b1);
    check_op("R1", 5, 1, 16'hA1A1, 1'b1);
    check_op("R3", 6, 1, 16'hB5B5, 1'b0);
    check_op("R4", 2, 1, m_crf[1], 1'b1);
    check_all("R1");
    @(negedge clk);
  endtask

  task automatic t_invalid(); // R5 R10
    clear_all();
    b_valid[1] = 1; b_done[1] = 1; b_wen[1][2] = 1; b_data[1][2] = 16'hD00D;
    b_valid[3] = 0; b_done[3] = 1; b_wen[3][2] = 1; b_data[3][2] = 16'hC0C0;
    b_wen[3][4] = 1; b_data[3][4] = 16'h4444;
    #1;
    check_op("R5", 4, 2, 16'hD00D, 1'b1);
    check_op("R5", 7, 4, m_crf[4], 1'b1);
    check_op("R10", 2, 3, m_crf[3], 1'b1);
    check_all("R5");
    @(negedge clk);
  endtask

  task automatic t_retire();  // R7
    clear_all();
    b_valid[m_head] = 1; b_done[m_head] = 1;
    b_wen[m_head][1] = 1; b_data[m_head][1] = 16'h1111;
    b_wen[m_head][5] = 1; b_data[m_head][5] = 16'h5555;
    b_data[m_head][3] = 16'h3333;  // not enabled
    begin
      int h0; logic [W-1:0] old3;
      h0 = m_head; old3 = m_crf[3];
      step();
      b_valid[h0] = 0; b_done[h0] = 0;
      #1;
      check_head("R7");
      check_op("R7", m_head, 1, 16'h1111, 1'b1);
      check_op("R7", m_head, 5, 16'h5555, 1'b1);
      check_op("R7", m_head, 3, old3, 1'b1);
      check_all("R7");
    end
  endtask

  task automatic t_stall();   // R8
    clear_all();
    b_valid[m_head] = 1; b_done[m_head] = 0;
    b_wen[m_head][0] = 1; b_data[m_head][0] = 16'hEEEE;
    begin
      int h0; logic [W-1:0] old0;
      h0 = m_head; old0 = m_crf[0];
      step(); #1;
      check_head("R8");
      check_op("R8", h0, 0, old0, 1'b1);
      b_valid[h0] = 0; #1;
      check_op("R8", (h0 + 1) % N, 0, old0, 1'b1);
    end
    @(negedge clk);
  endtask

  task automatic t_wrap();    // R6
    clear_all();
    while (m_head != 6) begin
      int h0;
      h0 = m_head;
      b_valid[h0] = 1; b_done[h0] = 1;
      step();
      b_valid[h0] = 0; b_done[h0] = 0;
    end
    #1;
    check_head("R6");
    b_valid[7] = 1; b_done[7] = 1; b_wen[7][2] = 1; b_data[7][2] = 16'hF7F7;
    b_valid[1] = 1; b_done[1] = 0; b_wen[1][2] = 1; b_data[1][2] = 16'hE1E1;
    #1;
    check_op("R6", 1, 2, 16'hF7F7, 1'b1);
    check_op("R6", 0, 2, 16'hF7F7, 1'b1);
    check_op("R6", 5, 2, 16'hE1E1, 1'b0);
    check_op("R6", 7, 2, m_crf[2], 1'b1);
    check_all("R6");
    @(negedge clk);
  endtask

  task automatic t_random();  // R1 R2 R3 R6 R7 R10
    for (int it = 0; it < 60; it++) begin
      for (int s = 0; s < N; s++) begin
        b_valid[s] = 1'($urandom);
        b_done[s]  = 1'($urandom);
        for (int r = 0; r < R; r++) begin
          b_wen[s][r]  = ($urandom % 4) == 0;
          b_data[s][r] = W'($urandom);
        end
      end
      #1;
      check_all("R1");
      step();
      #1;
      check_head("R7");
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_all();
    for (int r = 0; r < R; r++) m_crf[r] = '0;
    m_head = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain();
    t_invalid();
    t_retire();
    t_stall();
    t_wrap();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule